// File: doc/BRIEF.md
# Timer-Triggered Buffered Pulse Output Unit

This block drives an 8-bit group of output lines from a staged data byte. A free-running up-counter counts from zero up to a programmable terminal value and then wraps to zero. A second compare value marks a point inside each count cycle. A selected compare event copies the staged byte into the output register. A per-bit enable mask limits the copy to chosen lines, and every other line keeps its level.

Each transfer raises an interrupt flag. Host software, or a data-moving engine, uses this flag to write the next pattern while the current pattern is on the lines. The staged byte is double-buffered, so patterns change only on the timer event and never on a host write. A common use is stepper-motor phase drive. The five upper lines walk through a ten-step table in which one or two phases are high at any time.

Host access goes through a simple register port. A write takes effect on the clock edge at which it is presented. A read returns registered data one clock after the address is presented.

Top module: `pout_unit`

## Requirements
- R1: After a synchronous reset the counter, output byte, staged byte, enable mask, control and status are all zero, and the counter stays at zero until the run bit (CTRL bit 0) is set.
- R2: While running, the counter steps by one per clock and returns to zero on the clock after it equals the terminal value P, so compare-A events repeat every P+1 clocks. Clearing the run bit freezes the counter at its current value.
- R3: On a clock edge where the selected trigger is active, every output bit whose mask bit is 1 takes the staged byte's bit. The output changes on that edge and at no other time.
- R4: Output bits whose mask bit is 0 keep their value through every transfer.
- R5: CTRL bits 3:2 select the trigger: 00 none, 01 compare A (counter equals terminal value), 10 compare B (counter equals the B value), 11 either.
- R6: Each trigger sets the status flag. The irq output equals the flag AND the interrupt-enable bit (CTRL bit 1).
- R7: Status bit 0 is the flag and bit 1 is overrun. A trigger while the flag is set, with no clear in the same cycle, sets overrun. Writing 1 to a status bit clears it, but a trigger in the same cycle keeps the flag set.
- R8: A staged-byte write on the same edge as a trigger does not affect that transfer. The new value is used at the next trigger.
- R9: A terminal value of zero makes compare A true on every running clock, so a transfer happens on every edge.
- R10: With mask 0xF8 and compare A selected, staging 0x80, 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 in turn, once per interrupt, produces that sequence on the output. One or two upper lines are high, and the lower three lines stay low.
- R11: Register addresses: 0 control, 1 terminal value, 2 compare B, 3 staged byte, 4 mask, 5 status, 6 output (read only), 7 counter (read only). Read data appears on the clock after the read address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wdata | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rdata | output | CNT_W | Registered read data |
| pulse_out | output | GRP_W | Output line group |
| irq | output | 1 | Interrupt request |

## Verification
The transfer path is tested with several staged patterns. A full mask with bytes that differ in every bit exposes any stuck or swapped bit. A partial mask with a complementary byte separates copied lines from held lines. The ten-step phase table, with the host refilling on each interrupt, checks the double-buffering over many periods. Each trigger selection, the zero terminal value and a write that lands on the trigger edge are each timed to the exact clock, which tells an early or late transfer apart from a correct one.

// File: rtl/pout_pkg.sv
package pout_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_PERIOD = 3'd1,
    A_CMPB   = 3'd2,
    A_NEXT   = 3'd3,
    A_MASK   = 3'd4,
    A_STAT   = 3'd5,
    A_OUT    = 3'd6,
    A_CNT    = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    TRG_NONE = 2'b00,
    TRG_A    = 2'b01,
    TRG_B    = 2'b10,
    TRG_ANY  = 2'b11
  } trig_e;

  // control word: {trig[3:2], ie[1], run[0]}
  typedef struct packed {
    trig_e trig;
    logic  ie;
    logic  run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/pout_regs.sv
module pout_regs
  import pout_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] cmpb_q,
  output logic [GRP_W-1:0] next_q,
  output logic [GRP_W-1:0] mask_q,
  output logic [1:0]       clr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
      cmpb_q   <= '0;
      next_q   <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CTRL:   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_PERIOD: period_q <= wdata;
        A_CMPB:   cmpb_q   <= wdata;
        A_NEXT:   next_q   <= wdata[GRP_W-1:0];
        A_MASK:   mask_q   <= wdata[GRP_W-1:0];
        default:  ;
      endcase
    end
  end

  // write-one-to-clear strobes for the status bits
  assign clr = (wr_en && reg_addr_e'(wr_addr) == A_STAT) ? wdata[1:0] : 2'b00;

endmodule

// File: rtl/pout_timer.sv
module pout_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmpb,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_a,
  output logic             hit_b
);

  assign hit_a = run && (cnt == period);
  assign hit_b = run && (cnt == cmpb);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (run)
      cnt <= hit_a ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/pout_xfer.sv
module pout_xfer #(
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [GRP_W-1:0] next_q,
  input  logic [GRP_W-1:0] mask_q,
  input  logic [1:0]       clr,
  output logic [GRP_W-1:0] out_q,
  output logic             flag,
  output logic             ovr
);

  // one flop per output line; a line loads only when fired and enabled
  for (genvar b = 0; b < GRP_W; b++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        out_q[b] <= 1'b0;
      else if (fire && mask_q[b])
        out_q[b] <= next_q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (fire)
        flag <= 1'b1;
      else if (clr[0])
        flag <= 1'b0;

      if (fire && flag && !clr[0])
        ovr <= 1'b1;
      else if (clr[1])
        ovr <= 1'b0;
    end
  end

endmodule

// File: rtl/pout_unit.sv
module pout_unit
  import pout_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rdata,
  output logic [GRP_W-1:0] pulse_out,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cmpb;
  logic [GRP_W-1:0] next_q;
  logic [GRP_W-1:0] mask_q;
  logic [1:0]       clr;
  logic [CNT_W-1:0] cnt;
  logic             hit_a;
  logic             hit_b;
  logic             run;
  logic             fire;
  logic             flag;
  logic             ovr;

  pout_regs #(.CNT_W(CNT_W), .GRP_W(GRP_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .ctrl_q(ctrl_q), .period_q(period), .cmpb_q(cmpb),
    .next_q(next_q), .mask_q(mask_q), .clr(clr)
  );

  assign run = ctrl_q.run;

  pout_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .run(run), .period(period), .cmpb(cmpb),
    .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b)
  );

  always_comb begin
    case (ctrl_q.trig)
      TRG_A:   fire = hit_a;
      TRG_B:   fire = hit_b;
      TRG_ANY: fire = hit_a || hit_b;
      default: fire = 1'b0;
    endcase
  end

  pout_xfer #(.GRP_W(GRP_W)) xfer_i (
    .clk(clk), .rst(rst), .fire(fire), .next_q(next_q), .mask_q(mask_q),
    .clr(clr), .out_q(pulse_out), .flag(flag), .ovr(ovr)
  );

  assign irq = flag && ctrl_q.ie;

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else begin
      case (reg_addr_e'(rd_addr))
        A_CTRL:   rdata <= CNT_W'(ctrl_q);
        A_PERIOD: rdata <= period;
        A_CMPB:   rdata <= cmpb;
        A_NEXT:   rdata <= CNT_W'(next_q);
        A_MASK:   rdata <= CNT_W'(mask_q);
        A_STAT:   rdata <= CNT_W'({ovr, flag});
        A_OUT:    rdata <= CNT_W'(pulse_out);
        default:  rdata <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/pout_chk.sv
module pout_chk #(
  parameter int CNT_W = 16,
  parameter int GRP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             fire,
  input logic [GRP_W-1:0] next_q,
  input logic [GRP_W-1:0] mask_q,
  input logic [GRP_W-1:0] pulse_out,
  input logic             flag,
  input logic             ovr,
  input logic [1:0]       clr
);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == period) |=> (cnt == '0));

  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(pulse_out));

  p_take_r3: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((pulse_out & $past(mask_q)) == ($past(next_q) & $past(mask_q))));

  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((pulse_out & ~$past(mask_q)) == ($past(pulse_out) & ~$past(mask_q))));

  p_flag_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag);

  p_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && flag && !clr[0]) |=> ovr);

endmodule

bind pout_unit pout_chk #(.CNT_W(CNT_W), .GRP_W(GRP_W)) chk_i (
  .clk(clk), .rst(rst), .run(run), .cnt(cnt), .period(period), .fire(fire),
  .next_q(next_q), .mask_q(mask_q), .pulse_out(pulse_out), .flag(flag),
  .ovr(ovr), .clr(clr)
);

// File: tb/pout_unit_tb.sv
module pout_unit_tb_top;

  localparam int CNT_W = 16;
  localparam int GRP_W = 8;
  localparam logic [7:0] SEQ [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20,
                                      8'h30, 8'h10, 8'h18, 8'h08, 8'h88};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_addr = '0;
  logic [CNT_W-1:0] wdata = '0;
  logic [2:0]       rd_addr = '0;
  logic [CNT_W-1:0] rdata;
  logic [GRP_W-1:0] pulse_out;
  logic             irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pout_unit #(.CNT_W(CNT_W), .GRP_W(GRP_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .pulse_out(pulse_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(2);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk("R1 out", 16'(pulse_out), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
    step(8);
    rd(3'd7, v); chk("R1 counter stopped", v, 16'h0);
    rd(3'd3, v); chk("R1 staged", v, 16'h0);
    rd(3'd4, v); chk("R1 mask", v, 16'h0);
    rd(3'd5, v); chk("R1 status", v, 16'h0);
  endtask

  task automatic t_period();
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'hA5);
    wr(3'd0, 16'h7);          // start edge E0
    step(4);
    chk("R2 no transfer before P+1", 16'(pulse_out), 16'h0);
    step(1);
    chk("R3 transfer at P+1", 16'(pulse_out), 16'hA5);
    chk("R6 irq after match", 16'(irq), 16'h1);
    wr(3'd3, 16'h5A);         // E6
    step(3);                  // E9
    chk("R2 held until next match", 16'(pulse_out), 16'hA5);
    step(1);                  // E10
    chk("R2 second transfer", 16'(pulse_out), 16'h5A);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd2);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'hA5);
    wr(3'd0, 16'h5);
    step(4);
    chk("R3 full mask", 16'(pulse_out), 16'hA5);
    wr(3'd4, 16'hF8);
    wr(3'd3, 16'h5A);
    step(4);
    chk("R4 masked bits kept", 16'(pulse_out), 16'h5D);
    rd(3'd6, v); chk("R11 output readback", v, 16'h5D);
  endtask

  task automatic t_trig_b();
    do_reset();
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd1);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'h3C);
    wr(3'd0, 16'h9);          // trig B, run; E0
    step(1);
    chk("R5 B not yet", 16'(pulse_out), 16'h0);
    step(1);                  // E2
    chk("R5 B transfer", 16'(pulse_out), 16'h3C);
    wr(3'd3, 16'hC3);         // E3
    step(2);                  // E5: compare A edge
    chk("R5 compare A ignored", 16'(pulse_out), 16'h3C);
    step(1);
    chk("R5 B held", 16'(pulse_out), 16'h3C);
    step(1);                  // E7
    chk("R5 B second", 16'(pulse_out), 16'hC3);
  endtask

  task automatic t_trig_none();
    logic [15:0] v;
    do_reset();
    wr(3'd1, 16'd1);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'h77);
    wr(3'd0, 16'h3);          // no trigger, ie, run
    step(10);
    chk("R5 none no transfer", 16'(pulse_out), 16'h0);
    rd(3'd5, v); chk("R5 none no flag", v, 16'h0);
  endtask

  task automatic t_zero();
    do_reset();
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'h12);
    wr(3'd0, 16'h5);          // E0, period 0
    chk("R9 before first edge", 16'(pulse_out), 16'h0);
    wr(3'd3, 16'h34);         // E1
    chk("R9 first edge", 16'(pulse_out), 16'h12);
    step(1);
    chk("R9 every edge", 16'(pulse_out), 16'h34);
  endtask

  task automatic t_same_edge();
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'h11);
    wr(3'd0, 16'h5);          // E0
    step(3);
    wr(3'd3, 16'h22);         // lands on E4 = match edge
    chk("R8 old staged used", 16'(pulse_out), 16'h11);
    step(3);
    chk("R8 held", 16'(pulse_out), 16'h11);
    step(1);                  // E8
    chk("R8 new staged next match", 16'(pulse_out), 16'h22);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    logic [15:0] v2;
    do_reset();
    wr(3'd1, 16'd3);
    wr(3'd4, 16'hFF);
    wr(3'd3, 16'h01);
    wr(3'd0, 16'h5);          // ie off
    step(10);
    chk("R6 irq gated", 16'(irq), 16'h0);
    rd(3'd5, v); chk("R7 flag and overrun", v, 16'h3);
    wr(3'd0, 16'h4);          // stop
    rd(3'd7, v);
    step(5);
    rd(3'd7, v2); chk("R2 counter frozen", v2, v);
    wr(3'd5, 16'h3);
    rd(3'd5, v); chk("R7 w1c clear", v, 16'h0);
    wr(3'd0, 16'h7);
    step(6);
    chk("R6 irq raised", 16'(irq), 16'h1);
  endtask

  task automatic t_phase();
    logic [15:0] v;
    do_reset();
    wr(3'd4, 16'hF8);
    wr(3'd1, 16'd5);
    wr(3'd3, 16'h80);
    wr(3'd0, 16'h7);
    for (int i = 0; i < 20; i++) begin
      int guard = 0;
      while (!irq && guard < 20) begin
        step(1);
        guard++;
      end
      chk("R10 step value", 16'(pulse_out), 16'(SEQ[i % 10]));
      chk("R10 phases active", 16'(($countones(pulse_out[7:3]) inside {1, 2}) &&
                                    pulse_out[2:0] == 3'b000), 16'h1);
      wr(3'd3, 16'(SEQ[(i + 1) % 10]));
      wr(3'd5, 16'h1);
    end
    rd(3'd5, v); chk("R10 no overrun", 16'(v[1]), 16'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_period();
    t_mask();
    t_trig_b();
    t_trig_none();
    t_zero();
    t_same_edge();
    t_overrun();
    t_phase();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule